// File: doc/BRIEF.md
# Scalar Memory Load Unit

This block executes scalar load operations for a processor core. An issuing stage presents a destination register index, a base register pair index, an offset register selector, a signed immediate and a size code. On acceptance the unit reads the base pair and the offset register from its scalar register file. It forms a 64-bit byte address and emits one 32-bit word read per cycle on a simple valid/ready memory port. Responses come back in order and are written to consecutive destination registers.

A small descriptor queue decouples the request side from the write-back side. A new load can therefore be accepted while earlier loads still wait for data. An outstanding-load counter tracks every accepted load until its last word is written. A wait request compares that counter with a threshold and holds a stall output high until the count has drained far enough. A plain external write port, standing in for the scalar ALU, fills registers. A combinational observation port reads them.

Top module: `scalar_load_unit`

## Requirements
- R1: The byte address is the 64-bit base plus the zero-extended 32-bit offset register value plus the sign-extended 21-bit immediate, modulo 2^64. The base's low half is in the even register `issue_base` and its high half in the register above it.
- R2: An offset selector with its most significant bit set is the null selector and contributes zero to the address.
- R3: Negative immediates (for example -100) move the address downwards.
- R4: Size codes 0,1,2,3,4 load 1,2,4,8,16 words. Word k comes from address+4k and goes to register `issue_dst`+k.
- R5: Base and offset register values are sampled in the accept cycle. A destination that equals the offset register still uses the old offset.
- R6: A load is rejected if its destination index is not a multiple of its word count, its base index is odd, or its size code exceeds 4. A rejected load raises `issue_err` for one cycle after acceptance and issues no read. It writes no register and does not change the counter.
- R7: Each read is one word per handshake. `mem_req_valid` holds with a stable address until `mem_req_ready`, and `issue_ready` is low while a load's reads are being sent.
- R8: The counter rises by one per accepted legal load and falls by one when a load's last word is written. `stall` equals `wait_valid` and (counter > `wait_cnt`).
- R9: Read responses are taken in order, and each is written to the next destination register of the oldest unfinished load.
- R10: After reset all registers read zero, the counter is zero, no read is requested and `issue_ready` is high.
- R11: The external write port writes the addressed register. In the same cycle, a load write to the same register wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Load presented |
| issue_ready | output | 1 | Unit can accept a load |
| issue_dst | input | IDXW | First destination register |
| issue_base | input | IDXW | Even register of the base pair |
| issue_off_sel | input | IDXW+1 | Offset register selector, MSB set means none |
| issue_imm | input | IMMW | Signed immediate byte offset |
| issue_size | input | 3 | log2 of the word count |
| issue_err | output | 1 | Pulse: previous accepted load was rejected |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDRW | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATAW | Returned word |
| wait_valid | input | 1 | Wait request active |
| wait_cnt | input | CNTW | Allowed outstanding loads |
| stall | output | 1 | Wait not yet satisfied |
| ext_we | input | 1 | External register write enable |
| ext_addr | input | IDXW | External write register index |
| ext_data | input | DATAW | External write data |
| obs_addr | input | IDXW | Observation read index |
| obs_data | output | DATAW | Observation read data |

## Verification
The hardest state to reach is several loads in flight at once, with their reads already issued and the write-backs not yet done, because the memory normally answers quickly. The bench's memory model has a hold switch that parks responses. While it is set, the bench issues three loads back to back, probes the stall threshold just below and at the outstanding count, and then releases the memory. It checks that the queued responses land in issue order. The overlap of destination and offset register is reached by selecting the same index for both.

// File: rtl/slu_pkg.sv
// Shared constants, types and helpers for the scalar load unit.
// Assumes the size code is 3 bits wide and codes above 4 are illegal.
package slu_pkg;
    localparam int unsigned SLU_SIZEW    = 3;
    localparam int unsigned SLU_MAX_CODE = 4;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_SEND = 1'b1
    } req_state_e;

    function automatic logic size_code_ok(input logic [SLU_SIZEW-1:0] code);
        return code <= SLU_SIZEW'(SLU_MAX_CODE);
    endfunction
endpackage

// File: rtl/slu_regfile.sv
// Scalar register file: NRD combinational read ports and two write ports.
// Port A (load write-back) wins over port B (external) on the same index.
// Assumes NREG is a power of two.
module slu_regfile #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned DATAW = 32,
    parameter int unsigned NRD   = 4,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_a,
    input  logic [IDXW-1:0]           waddr_a,
    input  logic [DATAW-1:0]          wdata_a,
    input  logic                      we_b,
    input  logic [IDXW-1:0]           waddr_b,
    input  logic [DATAW-1:0]          wdata_b,
    input  logic [NRD-1:0][IDXW-1:0]  raddr,
    output logic [NRD-1:0][DATAW-1:0] rdata
);
    logic [DATAW-1:0] regs_q [NREG];

    // Register storage: reset to zero, external write first, load write last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
        end else begin
            if (we_b) regs_q[waddr_b] <= wdata_b;
            if (we_a) regs_q[waddr_a] <= wdata_a;
        end
    end

    // One combinational read path per port.
    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        assign rdata[p] = regs_q[raddr[p]];
    end
endmodule

// File: rtl/slu_issue_decode.sv
// Combinational issue decode: forms the 64-bit byte address and the word
// count, and checks size code, base pair parity and destination alignment.
// Assumes ADDRW == 2*DATAW and that NREG is at least the largest word count.
module slu_issue_decode
    import slu_pkg::*;
#(
    parameter int unsigned ADDRW = 64,
    parameter int unsigned DATAW = 32,
    parameter int unsigned IMMW  = 21,
    parameter int unsigned IDXW  = 5,
    parameter int unsigned WCW   = 5
) (
    input  logic [DATAW-1:0]     base_lo,
    input  logic [DATAW-1:0]     base_hi,
    input  logic [DATAW-1:0]     off_val,
    input  logic                 off_null,
    input  logic [IMMW-1:0]      imm,
    input  logic [SLU_SIZEW-1:0] size,
    input  logic [IDXW-1:0]      dst,
    input  logic [IDXW-1:0]      base_idx,
    output logic [ADDRW-1:0]     addr,
    output logic [WCW-1:0]       nwords,
    output logic                 legal
);
    logic [ADDRW-1:0] off_term;
    logic [ADDRW-1:0] imm_term;
    logic [IDXW-1:0]  align_mask;

    // Sum of base pair, optional offset register and sign-extended immediate.
    always_comb begin
        off_term = off_null ? '0 : ADDRW'(off_val);
        imm_term = {{(ADDRW-IMMW){imm[IMMW-1]}}, imm};
        addr     = {base_hi, base_lo} + off_term + imm_term;
    end

    // Word count and legality of the operand combination.
    always_comb begin
        nwords     = size_code_ok(size) ? (WCW'(1) << size) : WCW'(1);
        align_mask = IDXW'(nwords - WCW'(1));
        legal      = size_code_ok(size) && !base_idx[0] && ((dst & align_mask) == '0);
    end
endmodule

// File: rtl/slu_req_engine.sv
// Read request sequencer: after start, issues nwords word reads at
// consecutive 4-byte addresses, one per valid/ready handshake.
// Assumes start only arrives while busy is low.
module slu_req_engine
    import slu_pkg::*;
#(
    parameter int unsigned ADDRW = 64,
    parameter int unsigned WCW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ADDRW-1:0] start_addr,
    input  logic [WCW-1:0]   start_words,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [ADDRW-1:0] mem_req_addr
);
    req_state_e       state_q;
    logic [ADDRW-1:0] addr_q;
    logic [WCW-1:0]   left_q;

    // Request state, current address and words remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
        end else if (state_q == REQ_IDLE) begin
            if (start) begin
                state_q <= REQ_SEND;
                addr_q  <= start_addr;
                left_q  <= start_words;
            end
        end else if (mem_req_ready) begin
            addr_q <= addr_q + ADDRW'(4);
            left_q <= left_q - WCW'(1);
            if (left_q == WCW'(1)) state_q <= REQ_IDLE;
        end
    end

    // Port outputs come straight from state.
    assign busy          = (state_q == REQ_SEND);
    assign mem_req_valid = busy;
    assign mem_req_addr  = addr_q;
endmodule

// File: rtl/slu_desc_fifo.sv
// Descriptor queue between request and write-back sides, first in first out.
// Assumes DEPTH is a power of two and no push when full or pop when empty.
module slu_desc_fifo #(
    parameter int unsigned W     = 10,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    logic [W-1:0] mem_q [DEPTH];
    logic [PW:0]  wr_q, rd_q;

    // Pointer update with one wrap bit to tell full from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q[PW-1:0]] <= push_data;
    end

    assign head  = mem_q[rd_q[PW-1:0]];
    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[PW-1:0] == rd_q[PW-1:0]) && (wr_q[PW] != rd_q[PW]);
endmodule

// File: rtl/scalar_load_unit.sv
// Scalar load unit top: decodes a load at acceptance, sequences word reads,
// writes in-order responses to consecutive registers and counts loads in
// flight for a wait/stall comparison. Assumes memory answers in order and
// never returns more words than were requested.
module scalar_load_unit
    import slu_pkg::*;
#(
    parameter int unsigned NREG  = 32,
    parameter int unsigned DATAW = 32,
    parameter int unsigned ADDRW = 64,
    parameter int unsigned IMMW  = 21,
    parameter int unsigned QDEPTH = 4,
    parameter int unsigned CNTW  = 6,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned SELW = IDXW + 1,
    localparam int unsigned WCW  = SLU_MAX_CODE + 1,
    localparam int unsigned DW   = IDXW + WCW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    output logic                 issue_ready,
    input  logic [IDXW-1:0]      issue_dst,
    input  logic [IDXW-1:0]      issue_base,
    input  logic [SELW-1:0]      issue_off_sel,
    input  logic [IMMW-1:0]      issue_imm,
    input  logic [SLU_SIZEW-1:0] issue_size,
    output logic                 issue_err,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDRW-1:0]     mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [DATAW-1:0]     mem_rsp_data,
    input  logic                 wait_valid,
    input  logic [CNTW-1:0]      wait_cnt,
    output logic                 stall,
    input  logic                 ext_we,
    input  logic [IDXW-1:0]      ext_addr,
    input  logic [DATAW-1:0]     ext_data,
    input  logic [IDXW-1:0]      obs_addr,
    output logic [DATAW-1:0]     obs_data
);
    localparam int unsigned NRD = 4;

    logic [NRD-1:0][IDXW-1:0]  rd_addr;
    logic [NRD-1:0][DATAW-1:0] rd_data;
    logic [ADDRW-1:0] dec_addr;
    logic [WCW-1:0]   dec_words;
    logic             dec_legal;
    logic             accept, start, req_busy;
    logic             q_full, q_empty, q_pop;
    logic [DW-1:0]    q_head;
    logic [IDXW-1:0]  head_dst;
    logic [WCW-1:0]   head_words;
    logic [WCW-1:0]   wb_idx_q;
    logic             wb_last, wb_we;
    logic [IDXW-1:0]  wb_addr;
    logic [CNTW-1:0]  outst_q;

    // Register file read port assignment: base pair, offset, observation.
    always_comb begin
        rd_addr[0] = issue_base;
        rd_addr[1] = issue_base | IDXW'(1);
        rd_addr[2] = issue_off_sel[IDXW-1:0];
        rd_addr[3] = obs_addr;
    end

    slu_regfile #(.NREG(NREG), .DATAW(DATAW), .NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_a(wb_we), .waddr_a(wb_addr), .wdata_a(mem_rsp_data),
        .we_b(ext_we), .waddr_b(ext_addr), .wdata_b(ext_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    slu_issue_decode #(.ADDRW(ADDRW), .DATAW(DATAW), .IMMW(IMMW), .IDXW(IDXW), .WCW(WCW)) u_dec (
        .base_lo(rd_data[0]), .base_hi(rd_data[1]), .off_val(rd_data[2]),
        .off_null(issue_off_sel[SELW-1]), .imm(issue_imm), .size(issue_size),
        .dst(issue_dst), .base_idx(issue_base),
        .addr(dec_addr), .nwords(dec_words), .legal(dec_legal)
    );

    // Acceptance: only with the request side idle and queue room.
    assign issue_ready = !req_busy && !q_full;
    assign accept      = issue_valid && issue_ready;
    assign start       = accept && dec_legal;

    slu_req_engine #(.ADDRW(ADDRW), .WCW(WCW)) u_req (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(dec_addr),
        .start_words(dec_words), .busy(req_busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
    );

    slu_desc_fifo #(.W(DW), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(start), .push_data({issue_dst, dec_words}),
        .pop(q_pop), .head(q_head), .full(q_full), .empty(q_empty)
    );

    // Write-back target for the current response word.
    always_comb begin
        {head_dst, head_words} = q_head;
        wb_we   = mem_rsp_valid && !q_empty;
        wb_addr = head_dst + IDXW'(wb_idx_q);
        wb_last = (wb_idx_q == head_words - WCW'(1));
        q_pop   = wb_we && wb_last;
    end

    // Word index within the oldest unfinished load.
    always_ff @(posedge clk) begin
        if (!rst_n)      wb_idx_q <= '0;
        else if (q_pop)  wb_idx_q <= '0;
        else if (wb_we)  wb_idx_q <= wb_idx_q + WCW'(1);
    end

    // Outstanding-load counter: up on legal issue, down on final write.
    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= '0;
        else        outst_q <= outst_q + CNTW'(start) - CNTW'(q_pop);
    end

    // Rejection pulse, one cycle after an illegal load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) issue_err <= 1'b0;
        else        issue_err <= accept && !dec_legal;
    end

    assign stall    = wait_valid && (outst_q > wait_cnt);
    assign obs_data = rd_data[3];
endmodule

// File: rtl/slu_checker.sv
// Protocol checker for the scalar load unit, bound to every instance.
module slu_checker #(
    parameter int unsigned ADDRW = 64,
    parameter int unsigned CNTW  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic             issue_ready,
    input logic             issue_err,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [ADDRW-1:0] mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             wait_valid,
    input logic             stall,
    input logic [CNTW-1:0]  outstanding
);
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7
    no_issue_while_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !issue_ready);

    // R6
    issue_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready |=> mem_req_valid != issue_err);

    // R8
    stall_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_valid |-> !stall);

    // R9
    rsp_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> outstanding != '0);
endmodule

bind scalar_load_unit slu_checker #(.ADDRW(ADDRW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_err(issue_err), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .wait_valid(wait_valid),
    .stall(stall), .outstanding(outst_q)
);

// File: tb/scalar_load_unit_tb.sv
module scalar_load_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue_valid = 0;
    logic        issue_ready;
    logic [4:0]  issue_dst = 0, issue_base = 0;
    logic [5:0]  issue_off_sel = 0;
    logic [20:0] issue_imm = 0;
    logic [2:0]  issue_size = 0;
    logic        issue_err;
    logic        mem_req_valid, mem_req_ready = 0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        wait_valid = 0;
    logic [5:0]  wait_cnt = 0;
    logic        stall;
    logic        ext_we = 0;
    logic [4:0]  ext_addr = 0, obs_addr = 0;
    logic [31:0] ext_data = 0, obs_data;

    int tests = 0, fails = 0;
    bit done = 0, rsp_hold = 0;
    int cyc = 0;
    logic [31:0] sh [32];
    logic [63:0] exp_q [$];
    logic [63:0] pend_q [$];

    always #2.5 clk = ~clk;

    scalar_load_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_dst(issue_dst), .issue_base(issue_base), .issue_off_sel(issue_off_sel),
        .issue_imm(issue_imm), .issue_size(issue_size), .issue_err(issue_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .wait_valid(wait_valid),
        .wait_cnt(wait_cnt), .stall(stall), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_data(ext_data), .obs_addr(obs_addr), .obs_data(obs_data)
    );

    function automatic logic [31:0] memval(input logic [63:0] a);
        return (a[31:0] * 32'h0100_0193) ^ a[63:32] ^ 32'h5EED_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model and monitor: compares each request with the scoreboard
    // queue and answers in order unless held.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        mem_rsp_valid <= 1'b0;
        if (rst_n && !rsp_hold && pend_q.size() > 0 && cyc[0]) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= memval(pend_q.pop_front());
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (exp_q.size() == 0) chk(0, "R6 unexpected read", mem_req_addr, 64'h0);
            else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(mem_req_addr == e, "R1/R4 read address", mem_req_addr, e);
            end
            pend_q.push_back(mem_req_addr);
        end
    end

    task automatic rd(input int a, output logic [31:0] v);
        obs_addr = 5'(a);
        #1 v = obs_data;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        ext_we = 1; ext_addr = 5'(a); ext_data = d;
        @(negedge clk);
        ext_we = 0;
        sh[a] = d;
    endtask

    task automatic drain();
        @(negedge clk);
        wait_valid = 1; wait_cnt = 0;
        #1;
        while (stall) begin @(negedge clk); #1; end
        wait_valid = 0;
    endtask

    function automatic logic [63:0] ea_of(input int base, input logic [5:0] sel, input logic [20:0] imm);
        logic [63:0] off;
        off = sel[5] ? 64'h0 : {32'h0, sh[sel[4:0]]};
        return {sh[base+1], sh[base]} + off + {{43{imm[20]}}, imm};
    endfunction

    // Driver: pushes expected reads, issues the load, checks the outcome.
    task automatic do_load(input int dst, input int base, input logic [5:0] sel,
                           input logic [20:0] imm, input int sz, input bit bad,
                           input bit wait_done, input string req);
        logic [63:0] ea;
        int nw;
        ea = ea_of(base, sel, imm);
        nw = 1 << sz;
        if (!bad) for (int k = 0; k < nw; k++) exp_q.push_back(ea + 64'(4*k));
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        issue_valid = 1; issue_dst = 5'(dst); issue_base = 5'(base);
        issue_off_sel = sel; issue_imm = imm; issue_size = 3'(sz);
        @(negedge clk);
        issue_valid = 0;
        chk(issue_err == bad, {req, " R6 err flag"}, 64'(issue_err), 64'(bad));
        if (!bad && wait_done) begin
            drain();
            for (int k = 0; k < nw; k++) begin
                logic [31:0] v;
                rd(dst + k, v);
                chk(v == memval(ea + 64'(4*k)), {req, " data"}, 64'(v), 64'(memval(ea + 64'(4*k))));
                sh[dst+k] = memval(ea + 64'(4*k));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        for (int i = 0; i < 32; i++) sh[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(issue_ready == 1, "R10 ready", 64'(issue_ready), 1);
        chk(mem_req_valid == 0, "R10 no read", 64'(mem_req_valid), 0);
        wait_valid = 1; wait_cnt = 0; #1;
        chk(stall == 0, "R10 counter zero", 64'(stall), 0);
        wait_valid = 0;
        rd(5, v);
        chk(v == 0, "R10 reg zero", 64'(v), 0);

        // R11 external writes
        wr(2, 32'h0000_1000); wr(3, 32'h0000_0001); wr(4, 4); wr(7, 0);
        wr(10, 32'h0000_10C8); wr(11, 1);
        wr(20, 32'hFFFF_FFFC); wr(21, 32'hFFFF_FFFF);
        rd(10, v);
        chk(v == 32'h10C8, "R11 ext write", 64'(v), 64'h10C8);

        // R1 register offset plus immediate
        do_load(5, 2, 6'd4, 21'd2000, 0, 0, 1, "R1 reg+imm");
        // R2 null selector
        do_load(6, 2, 6'h20, 21'd2000, 0, 0, 1, "R2 null offset");
        // R1 reg 4 + imm 0 equals reg 0 + imm 4
        do_load(8, 2, 6'd4, 21'd0, 0, 0, 1, "R1 split A");
        do_load(9, 2, 6'd7, 21'd4, 0, 0, 1, "R1 split B");
        rd(8, v); rd(9, v2);
        chk(v == v2, "R1 same word", 64'(v), 64'(v2));
        // R3 negative immediate
        do_load(12, 10, 6'h20, 21'h1FFF9C, 0, 0, 1, "R3 imm -100");
        // R5 destination equals offset register
        do_load(4, 2, 6'd4, 21'd2000, 0, 0, 1, "R5 dst=offset");
        rd(4, v);
        chk(v == memval(64'h1_0000_1000 + 2004), "R5 old offset", 64'(v), 64'(memval(64'h1_0000_1000 + 2004)));
        // R1 wrap modulo 2^64, two words
        do_load(0, 20, 6'h20, 21'd8, 1, 0, 1, "R1 wrap");
        // R4 sizes
        do_load(14, 2, 6'h20, 21'd0, 1, 0, 1, "R4 two words");
        do_load(16, 2, 6'h20, 21'd16, 2, 0, 1, "R4 four words");
        do_load(24, 2, 6'h20, 21'd64, 3, 0, 1, "R4 eight words");
        do_load(16, 2, 6'h20, 21'd128, 4, 0, 1, "R4 sixteen words");

        // R6 rejections: misaligned destination, odd base, bad size code
        do_load(6, 2, 6'h20, 21'd0, 2, 1, 0, "R6 misaligned dst");
        do_load(5, 3, 6'h20, 21'd0, 0, 1, 0, "R6 odd base");
        do_load(8, 2, 6'h20, 21'd0, 5, 1, 0, "R6 size code 5");
        repeat (6) @(negedge clk);
        rd(6, v);
        chk(v == sh[6], "R6 no write", 64'(v), 64'(sh[6]));
        wait_valid = 1; wait_cnt = 0; #1;
        chk(stall == 0, "R6 R8 counter unchanged", 64'(stall), 0);
        wait_valid = 0;

        // R8 R9 three loads in flight with responses held
        rsp_hold = 1;
        do_load(1, 2, 6'h20, 21'd300, 0, 0, 0, "R8 q1");
        do_load(2, 2, 6'h20, 21'd304, 0, 0, 0, "R8 q2");
        do_load(3, 2, 6'h20, 21'd308, 0, 0, 0, "R8 q3");
        repeat (8) @(negedge clk);
        wait_valid = 1; wait_cnt = 2; #1;
        chk(stall == 1, "R8 stall above threshold", 64'(stall), 1);
        wait_cnt = 3; #1;
        chk(stall == 0, "R8 no stall at threshold", 64'(stall), 0);
        wait_valid = 0;
        rsp_hold = 0;
        drain();
        for (int k = 1; k <= 3; k++) begin
            logic [63:0] a;
            a = 64'h1_0000_1000 + 64'(300 + 4*(k-1));
            rd(k, v);
            chk(v == memval(a), "R9 in-order write-back", 64'(v), 64'(memval(a)));
        end
        chk(exp_q.size() == 0, "R7 all reads issued", 64'(exp_q.size()), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule